// File: doc/BRIEF.md
# Cause-Dependent Reset Sequencer

This block collects every reason a microcontroller can be reset and turns them into one system reset. It runs on the always-available internal RC clock. The four causes are a power-on or low-voltage event, the external reset pin, a software request and a watchdog expiry. The system reset stays asserted for a number of RC cycles that depends on the cause. A cold start (power) and the reset pin allow time for oscillator stabilization and add an extension period. A software or watchdog reset only covers the stabilization time. When another cause arrives while the counter is still running, the count starts over, and it always uses the longer of the two lengths that apply.

The block also drives a sticky register of cause flags that software can read. Only a power event clears that register. A second output, `ram_ok`, tells downstream logic whether RAM may be trusted. RAM is never trusted after a power event. After a warm reset it is trusted, except for the topmost 4-byte word, which the boot code overwrites. The power input works as an asynchronous active-low reset and is released through a synchronizer. The reset pin is synchronized and then filtered, so that a pulse shorter than the acceptance window has no effect.

Top module: `reset_sequencer`

## Requirements
- R1: After `por_n` is deasserted, `sys_rst_n` stays low and rises at the 766th rising clock edge that follows. This is two synchronizer stages plus 764 cycles (64 stabilization plus 700 extension).
- R2: While `ext_rst_n` is accepted low, `sys_rst_n` is held low. After the pin returns high, `sys_rst_n` rises at the 767th rising edge: two synchronizer stages, one filter stage, then 764 cycles.
- R3: `ext_rst_n` is accepted only after `EXT_MIN_CYC` consecutive low samples (default 1). A low pulse that does not span a clock edge leaves `sys_rst_n`, `cause_flags` and `ram_ok` unchanged.
- R4: If `sw_rst_req` is high at rising edge S, `sys_rst_n` is low from edge S and rises at edge S+64.
- R5: If `wdt_expire` is high at rising edge S, `sys_rst_n` is low from edge S and rises at edge S+64.
- R6: A software or watchdog cause that arrives during a 64-cycle sequence reloads the full 64 cycles.
- R7: A software or watchdog cause that arrives during a 764-cycle sequence reloads 764 cycles, not 64.
- R8: An external reset that arrives during a 64-cycle sequence converts it into a 764-cycle sequence, counted from the pin's release.
- R9: `cause_flags` bit 0 = power, bit 1 = external, bit 2 = software, bit 3 = watchdog. Each bit is set when its cause is taken. Bits are never cleared, except by a power event, which sets the register to 4'b0001.
- R10: `ram_ok` is 0 after a power event and becomes 1 when any other cause is taken. Only a power event clears it.
- R11: While `por_n` is low, `sys_rst_n` = 0, `cause_flags` = 4'b0001 and `ram_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal RC clock |
| por_n | input | 1 | Power-on / low-voltage reset, asynchronous, active low |
| ext_rst_n | input | 1 | Raw external reset pin, asynchronous, active low |
| sw_rst_req | input | 1 | One-cycle strobe from a write of 1 to the reset-generate bit |
| wdt_expire | input | 1 | Watchdog expiry pulse, synchronous |
| sys_rst_n | output | 1 | System reset to the core and peripherals, active low |
| cause_flags | output | 4 | Sticky cause register (encoding in R9) |
| ram_ok | output | 1 | RAM contents retained (except the top word) |

## Verification
Some properties are checked on every cycle by the embedded properties:
- an accepted pin level or a warm-reset strobe drives the system reset low on the next edge;
- the release never happens in a cycle that still has an active cause;
- the counter stays within the long length, and a warm cause during a long sequence keeps the long reload;
- cause flags only ever accumulate;
- `ram_ok` rises only after a warm cause.

The exact release cycle for each cause, the restart lengths when causes overlap, the rejection of a narrow pin pulse, and the clearing by a second power event can only be shown by the scenarios. In those scenarios the scoreboard compares the measured low time of each reset episode against its expected length.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int CAUSE_W  = 4;
  localparam int C_POWER  = 0;
  localparam int C_PIN    = 1;
  localparam int C_SOFT   = 2;
  localparam int C_WDOG   = 3;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t COLD_FLAGS = cause_t'(1 << C_POWER);
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int EXT_MIN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  output logic accepted
);
  localparam int RUN_W = $clog2(EXT_MIN_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(EXT_MIN_CYC);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (pin_sync)            run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign accepted = (run_q == RUN_MAX);

  p_accept_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accepted) |-> $past(pin_sync == 1'b0));
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int STAB_CYC   = 64,
  parameter int EXTEND_CYC = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_long,
  input  logic kick_short,
  output logic sys_rst_n
);
  localparam int LONG_CYC = STAB_CYC + EXTEND_CYC;
  localparam int CNT_W    = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(STAB_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             long_q, long_d;
  logic             out_q, out_d;

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (hold_long) begin
      cnt_d  = LONG_V;
      long_d = 1'b1;
    end else if (kick_short) begin
      if (long_q && (cnt_q != '0)) begin
        cnt_d = LONG_V;
      end else begin
        cnt_d  = SHORT_V;
        long_d = 1'b0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    out_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LONG_V;
      long_q <= 1'b1;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
      out_q  <= out_d;
    end
  end

  assign sys_rst_n = out_q;

  p_hold_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_long |=> !sys_rst_n);
  p_kick_asserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_short |=> !sys_rst_n);
  p_release_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(!hold_long && !kick_short));
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_V);
  p_long_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (long_q && (cnt_q != '0) && kick_short && !hold_long) |=> (cnt_q == LONG_V));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC    = 64,
  parameter int EXTEND_CYC  = 700,
  parameter int EXT_MIN_CYC = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               ext_rst_n,
  input  logic               sw_rst_req,
  input  logic               wdt_expire,
  output logic               sys_rst_n,
  output logic [CAUSE_W-1:0] cause_flags,
  output logic               ram_ok
);
  logic   por_ok;
  logic   pin_sync;
  logic   pin_taken;
  logic   warm_kick;
  cause_t cause_q, cause_d;
  logic   ram_q, ram_d;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(por_ok));

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(pin_sync));

  rstseq_pin_filter #(.EXT_MIN_CYC(EXT_MIN_CYC)) u_pin_filter (
    .clk(clk), .rst_n(por_n), .pin_sync(pin_sync), .accepted(pin_taken));

  assign warm_kick = sw_rst_req | wdt_expire;

  rstseq_timer #(.STAB_CYC(STAB_CYC), .EXTEND_CYC(EXTEND_CYC)) u_timer (
    .clk(clk), .rst_n(por_n), .hold_long(!por_ok || pin_taken),
    .kick_short(warm_kick), .sys_rst_n(sys_rst_n));

  always_comb begin
    cause_d          = cause_q;
    cause_d[C_PIN]   = cause_q[C_PIN]  | pin_taken;
    cause_d[C_SOFT]  = cause_q[C_SOFT] | sw_rst_req;
    cause_d[C_WDOG]  = cause_q[C_WDOG] | wdt_expire;
    ram_d            = ram_q | pin_taken | warm_kick;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= COLD_FLAGS;
      ram_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      ram_q   <= ram_d;
    end
  end

  assign cause_flags = cause_q;
  assign ram_ok      = ram_q;

  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    ((cause_q & $past(cause_q)) == $past(cause_q)));
  p_ram_warm_only_r10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ram_q) |-> $past(pin_taken || sw_rst_req || wdt_expire));
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
  localparam int SHORT = 64;
  localparam int LONG  = 764;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, sw_rst_req, wdt_expire;
  logic       sys_rst_n, ram_ok;
  logic [3:0] cause_flags;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int run_cnt = 0;
  logic prev_low = 1'b0;

  always #4 clk = ~clk;

  reset_sequencer u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sw_rst_req(sw_rst_req),
    .wdt_expire(wdt_expire), .sys_rst_n(sys_rst_n), .cause_flags(cause_flags),
    .ram_ok(ram_ok));

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_len(string req, int len);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  // monitor: measures reset low time counted from the release of held causes
  always @(negedge clk) begin
    if (!por_n || !ext_rst_n) run_cnt = 0;
    else if (!sys_rst_n) run_cnt++;
    else if (prev_low) begin
      if (exp_q.size() == 0) check("unexpected release", run_cnt, -1);
      else check(tag_q.pop_front(), run_cnt, exp_q.pop_front());
      run_cnt = 0;
    end
    prev_low = !sys_rst_n;
  end

  task automatic pulse_sw();
    @(posedge clk); #1 sw_rst_req = 1'b1;
    @(posedge clk); #1 sw_rst_req = 1'b0;
  endtask

  task automatic pulse_wdt();
    @(posedge clk); #1 wdt_expire = 1'b1;
    @(posedge clk); #1 wdt_expire = 1'b0;
  endtask

  task automatic wait_release();
    while (!sys_rst_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; sw_rst_req = 1'b0; wdt_expire = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 sys_rst_n", sys_rst_n, 0);
    check("R11 cause_flags", cause_flags, 4'b0001);
    check("R11 ram_ok", ram_ok, 0);

    expect_len("R1 power length", LONG + 2);
    @(posedge clk); #1 por_n = 1'b1;
    wait_release();
    check("R9 flags after power", cause_flags, 4'b0001);
    check("R10 ram after power", ram_ok, 0);
    repeat (5) @(posedge clk);

    // R3: pulse between edges must be ignored
    @(posedge clk); #1 ext_rst_n = 1'b0; #2 ext_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 glitch sys_rst_n", sys_rst_n, 1);
    check("R3 glitch flags", cause_flags, 4'b0001);
    check("R3 glitch ram_ok", ram_ok, 0);

    expect_len("R4 software length", SHORT);
    pulse_sw();
    wait_release();
    check("R9 flags after software", cause_flags, 4'b0101);
    check("R10 ram after software", ram_ok, 1);

    expect_len("R5 watchdog length", SHORT);
    pulse_wdt();
    wait_release();
    check("R9 flags after watchdog", cause_flags, 4'b1101);

    expect_len("R6 short restart", 18 + 2 + SHORT);
    pulse_sw();
    repeat (18) @(posedge clk);
    pulse_wdt();
    wait_release();

    expect_len("R2 external length", LONG + 3);
    @(posedge clk); #1 ext_rst_n = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R2 held low", sys_rst_n, 0);
    @(posedge clk); #1 ext_rst_n = 1'b1;
    wait_release();
    check("R9 flags after external", cause_flags, 4'b1111);

    expect_len("R7 long kept", 50 + 2 + LONG);
    @(posedge clk); #1 ext_rst_n = 1'b0;
    repeat (10) @(posedge clk);
    @(posedge clk); #1 ext_rst_n = 1'b1;
    repeat (50) @(posedge clk);
    pulse_wdt();
    wait_release();

    expect_len("R8 short upgraded", LONG + 3);
    pulse_sw();
    repeat (10) @(posedge clk);
    #1 ext_rst_n = 1'b0;
    repeat (10) @(posedge clk);
    @(posedge clk); #1 ext_rst_n = 1'b1;
    wait_release();
    check("R10 ram kept warm", ram_ok, 1);

    @(posedge clk); #1 por_n = 1'b0;
    @(negedge clk);
    check("R9 power clears flags", cause_flags, 4'b0001);
    check("R10 power clears ram_ok", ram_ok, 0);
    check("R11 sys low in power", sys_rst_n, 0);
    expect_len("R1 second power length", LONG + 2);
    repeat (3) @(posedge clk);
    @(posedge clk); #1 por_n = 1'b1;
    wait_release();
    check("R1 no pending expectations", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule